// File: doc/BRIEF.md
# Nibble-Serial 64-Bit Block Cipher Core

This core encrypts one 64-bit block under an 80-bit key with a substitution-permutation network of 31 rounds and a closing key addition. The whole datapath is four bits wide. A single 4-bit substitution box is used in turn by the data nibbles and by the key schedule. The 64-bit state lives in sixteen nibble registers and the key in twenty. Both chains either shift one nibble per clock or apply a whole-word transform in one clock.

A host pulses `start` and then presents twenty key nibbles on consecutive cycles. Plaintext nibbles are presented alongside the first sixteen of them. The core then runs unattended. When the ciphertext is ready it raises `done` for one cycle and places the sixteen ciphertext nibbles on `dataOut`, one per cycle. Outside that window the output is forced to zero.

Top module: `nibble_cipher_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `dataOut` is 0 and `done` is 0.
- R2: The 4-bit substitution maps inputs 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 and is used both for every state nibble and for the key schedule.
- R3: The bit permutation moves state bit i (bit 0 = LSB) to bit (16*i) mod 63 for i below 63, and leaves bit 63 in place.
- R4: The round key is bits 79..16 of the key register. After each round the key register is rotated left by 61, then bits 79..76 pass through the substitution, then bits 19..15 are XORed with the round number. The round number runs from 1 to 31.
- R5: A block is transformed by 31 rounds of key addition, substitution and permutation, followed by a final key addition. For example, an all-zero plaintext under an all-zero key yields 5579C1387B228445.
- R6: A `start` sampled while idle is followed by 20 load cycles. In each of these, `keyIn` is taken most-significant nibble first. In the first 16 of them, `dataIn` is also taken most-significant nibble first.
- R7: The first ciphertext nibble is on `dataOut` in the cycle after the 547th rising edge following the edge that sampled `start`. The other 15 nibbles follow on consecutive cycles, most-significant first.
- R8: `done` is high for exactly one cycle, the cycle that carries the first ciphertext nibble.
- R9: `dataOut` is 0 in every cycle outside the 16-cycle ciphertext window.
- R10: `start` has no effect while a block is being loaded, encrypted or output. The running block's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new block when idle |
| dataIn | input | 4 | Plaintext nibble during the load phase |
| keyIn | input | 4 | Key nibble during the load phase |
| dataOut | output | 4 | Ciphertext nibble, zero outside the output window |
| done | output | 1 | One-cycle flag marking the first ciphertext nibble |

## Verification
Every result is counted in rising edges from the edge that samples `start`:
- Load nibble k is consumed at edge k+1.
- Ciphertext nibble j is valid after edge 547+j.
- `done` is seen only after edge 547.

The bench drives and samples on falling edges, so each expected value is read exactly half a cycle after the edge that produces it. It also checks that `done` and `dataOut` stay quiet on every cycle before that window and after it. Expected ciphertexts come from a word-level model in the bench, and four published answer vectors confirm that model.

// File: rtl/nibcipher_pkg.sv
package nibcipher_pkg;
  localparam int NIB_W      = 4;
  localparam int STATE_NIBS = 16;
  localparam int KEY_NIBS   = 20;
  localparam int STATE_W    = NIB_W * STATE_NIBS;
  localparam int KEY_W      = NIB_W * KEY_NIBS;
  localparam int ROUNDS     = 31;
  localparam int RC_W       = 5;
  localparam int CNT_W      = 5;
  localparam int RC_LSB     = 15;
  localparam int KEY_ROT_L  = 61;
  localparam int PERM_MUL   = 16;
  // rotation still owed after the key chain spun STATE_NIBS nibbles during a round
  localparam int FIX_ROT    = (KEY_ROT_L + KEY_W - (STATE_W % KEY_W)) % KEY_W;

  typedef struct packed {
    logic            loadKey;
    logic            loadData;
    logic            subStep;
    logic            update;
    logic            outStep;
    logic            outEn;
    logic [RC_W-1:0] roundCnt;
  } ctl_t;

  function automatic logic [NIB_W-1:0] subNib(input logic [NIB_W-1:0] x);
    logic [NIB_W-1:0] y;
    case (x)
      4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
      4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
      4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
      4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
    endcase
    return y;
  endfunction
endpackage

// File: rtl/nibcipher_sbox.sv
module nibcipher_sbox
  import nibcipher_pkg::*;
(
  input  logic [NIB_W-1:0] nibIn,
  output logic [NIB_W-1:0] nibOut
);
  always_comb nibOut = subNib(nibIn);
endmodule

// File: rtl/nibcipher_ctrl.sv
module nibcipher_ctrl
  import nibcipher_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output ctl_t ctl,
  output logic done
);
  typedef enum logic [2:0] {PH_IDLE, PH_LOAD, PH_ROUND, PH_OUT} phase_t;

  localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(KEY_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_NIBS = CNT_W'(STATE_NIBS);
  localparam logic [CNT_W-1:0] UPD_SLOT  = CNT_W'(STATE_NIBS);
  localparam logic [CNT_W-1:0] OUT_LAST  = CNT_W'(STATE_NIBS - 1);
  localparam logic [RC_W-1:0]  LAST_RND  = RC_W'(ROUNDS);

  phase_t           phase;
  logic [CNT_W-1:0] nibCnt;
  logic [RC_W-1:0]  roundCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      nibCnt   <= '0;
      roundCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_LOAD;
          nibCnt <= '0;
        end
        PH_LOAD: if (nibCnt == LOAD_LAST) begin
          phase    <= PH_ROUND;
          nibCnt   <= '0;
          roundCnt <= RC_W'(1);
        end else begin
          nibCnt <= nibCnt + 1'b1;
        end
        PH_ROUND: if (nibCnt == UPD_SLOT) begin
          nibCnt <= '0;
          if (roundCnt == LAST_RND) phase <= PH_OUT;
          else roundCnt <= roundCnt + 1'b1;
        end else begin
          nibCnt <= nibCnt + 1'b1;
        end
        PH_OUT: if (nibCnt == OUT_LAST) begin
          phase  <= PH_IDLE;
          nibCnt <= '0;
        end else begin
          nibCnt <= nibCnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.roundCnt = roundCnt;
    ctl.loadKey  = (phase == PH_LOAD);
    ctl.loadData = (phase == PH_LOAD) && (nibCnt < DATA_NIBS);
    ctl.subStep  = (phase == PH_ROUND) && (nibCnt != UPD_SLOT);
    ctl.update   = (phase == PH_ROUND) && (nibCnt == UPD_SLOT);
    ctl.outStep  = (phase == PH_OUT);
    ctl.outEn    = (phase == PH_OUT);
    done         = (phase == PH_OUT) && (nibCnt == '0);
  end
endmodule

// File: rtl/nibcipher_datapath.sv
module nibcipher_datapath
  import nibcipher_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic [NIB_W-1:0] dataIn,
  input  logic [NIB_W-1:0] keyIn,
  output logic [NIB_W-1:0] dataOut
);
  logic [STATE_W-1:0] stateR;
  logic [KEY_W-1:0]   keyR;
  logic [STATE_W-1:0] permState;
  logic [KEY_W-1:0]   keyRot;
  logic [KEY_W-1:0]   keyNext;
  logic [NIB_W-1:0]   stateTop, keyTop, mixNib, sboxIn, sboxOut;

  assign stateTop = stateR[STATE_W-1 -: NIB_W];
  assign keyTop   = keyR[KEY_W-1 -: NIB_W];
  assign mixNib   = stateTop ^ keyTop;

  // one substitution box, shared between data nibbles and the key update
  assign sboxIn = ctl.update ? keyRot[KEY_W-1 -: NIB_W] : mixNib;
  nibcipher_sbox u_sbox (.nibIn(sboxIn), .nibOut(sboxOut));

  // bit permutation: bit b goes to (PERM_MUL*b) mod (STATE_W-1), top bit fixed
  for (genvar b = 0; b < STATE_W; b++) begin : g_perm
    localparam int DST = (b == STATE_W-1) ? b : (b * PERM_MUL) % (STATE_W-1);
    assign permState[DST] = stateR[b];
  end

  // the key chain sits STATE_W bits ahead after a round; finish the rotation
  assign keyRot = {keyR[KEY_W-FIX_ROT-1:0], keyR[KEY_W-1:KEY_W-FIX_ROT]};

  always_comb begin
    keyNext = keyRot;
    keyNext[KEY_W-1 -: NIB_W] = sboxOut;
    keyNext[RC_LSB +: RC_W]   = keyRot[RC_LSB +: RC_W] ^ ctl.roundCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= '0;
      keyR   <= '0;
    end else if (ctl.loadKey) begin
      keyR <= {keyR[KEY_W-NIB_W-1:0], keyIn};
      if (ctl.loadData) stateR <= {stateR[STATE_W-NIB_W-1:0], dataIn};
    end else if (ctl.subStep) begin
      stateR <= {stateR[STATE_W-NIB_W-1:0], sboxOut};
      keyR   <= {keyR[KEY_W-NIB_W-1:0], keyTop};
    end else if (ctl.update) begin
      stateR <= permState;
      keyR   <= keyNext;
    end else if (ctl.outStep) begin
      stateR <= {stateR[STATE_W-NIB_W-1:0], {NIB_W{1'b0}}};
      keyR   <= {keyR[KEY_W-NIB_W-1:0], keyTop};
    end
  end

  assign dataOut = mixNib & {NIB_W{ctl.outEn}};
endmodule

// File: rtl/nibble_cipher_core.sv
module nibble_cipher_core
  import nibcipher_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NIB_W-1:0] dataIn,
  input  logic [NIB_W-1:0] keyIn,
  output logic [NIB_W-1:0] dataOut,
  output logic             done
);
  ctl_t ctl;

  nibcipher_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl), .done(done)
  );

  nibcipher_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .dataIn(dataIn), .keyIn(keyIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/cipher_core_chk.sv
module cipher_core_chk
  import nibcipher_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             done,
  input logic [NIB_W-1:0] dataOut,
  input ctl_t             ctl
);
  localparam int RUN_CW   = 10;
  localparam int DONE_AT  = KEY_NIBS + ROUNDS * (STATE_NIBS + 1);
  localparam int RUN_LAST = DONE_AT + STATE_NIBS;

  logic              run;
  logic [RUN_CW-1:0] runCnt;
  logic [NIB_W-1:0]  winCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run    <= 1'b0;
      runCnt <= '0;
      winCnt <= '0;
    end else begin
      if (!run && start) begin
        run    <= 1'b1;
        runCnt <= '0;
      end else if (run) begin
        runCnt <= runCnt + 1'b1;
        if (runCnt == RUN_CW'(RUN_LAST)) run <= 1'b0;
      end
      if (done) winCnt <= NIB_W'(STATE_NIBS - 1);
      else if (winCnt != '0) winCnt <= winCnt - 1'b1;
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R7
  done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (run && runCnt == RUN_CW'(DONE_AT)));

  // R9
  out_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut != '0) |-> (done || winCnt != '0));

  // R9
  out_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut != '0) |-> ctl.outEn);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadKey, ctl.subStep, ctl.update, ctl.outStep}));

  // R6
  data_in_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadData |-> ctl.loadKey);

  // R4
  round_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.update |-> (ctl.roundCnt != '0 && ctl.roundCnt <= RC_W'(ROUNDS)));

  // R10
  idle_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && runCnt < RUN_CW'(KEY_NIBS)) |-> ctl.loadKey);
endmodule

bind nibble_cipher_core cipher_core_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .dataOut(dataOut), .ctl(ctl)
);

// File: tb/nibble_cipher_core_tb.sv
`timescale 1ns/1ps
module nibble_cipher_core_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] dataIn = '0;
  logic [3:0] keyIn = '0;
  logic [3:0] dataOut;
  logic       done;

  int checks = 0;
  int fails  = 0;

  localparam int FIRST_OUT = 547;

  always #2 clk = ~clk;

  nibble_cipher_core u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .dataIn(dataIn), .keyIn(keyIn), .dataOut(dataOut), .done(done)
  );

  // ---- word-level reference built from the requirements ----
  function automatic logic [3:0] refSub(input logic [3:0] x);
    logic [63:0] tbl = 64'hC56B90AD3EF84712;
    return tbl[(15 - x) * 4 +: 4];
  endfunction

  function automatic logic [63:0] refEnc(input logic [63:0] pt, input logic [79:0] key);
    logic [63:0] st = pt;
    logic [63:0] tmp;
    logic [79:0] k = key;
    for (int r = 1; r <= 31; r++) begin
      st = st ^ k[79:16];
      for (int n = 0; n < 16; n++) st[n*4 +: 4] = refSub(st[n*4 +: 4]);
      tmp = '0;
      for (int b = 0; b < 64; b++) tmp[(b == 63) ? 63 : (b * 16) % 63] = st[b];
      st = tmp;
      k = {k[18:0], k[79:19]};
      k[79:76] = refSub(k[79:76]);
      k[19:15] = k[19:15] ^ 5'(r);
    end
    return st ^ k[79:16];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run one block; startHeld keeps start high for the whole run (R10)
  task automatic runBlock(input logic [63:0] pt, input logic [79:0] key,
                          input logic [63:0] expCt, input string tag, input bit startHeld);
    logic [63:0] got = '0;
    bit quiet = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);                       // edge 0 sampled start
    for (int i = 0; i < 20; i++) begin    // R6: load, MS nibble first
      start  = startHeld;
      keyIn  = key[79 - 4*i -: 4];
      dataIn = (i < 16) ? pt[63 - 4*i -: 4] : 4'hA;
      @(negedge clk);
      if (done || dataOut != 0) quiet = 1'b0;
    end
    keyIn = 4'h5; dataIn = 4'h9;
    for (int c = 21; c < FIRST_OUT; c++) begin
      @(negedge clk);
      if (done || dataOut != 0) quiet = 1'b0;
    end
    @(negedge clk);                       // after edge 547
    check(quiet, {"R9 quiet before output ", tag}, 64'(quiet), 64'd1);
    check(done === 1'b1, {"R7 R8 done at 547 ", tag}, 64'(done), 64'd1);
    for (int j = 0; j < 16; j++) begin
      got[63 - 4*j -: 4] = dataOut;
      check(dataOut === expCt[63 - 4*j -: 4], {"R5 R7 nibble ", tag},
            64'(dataOut), 64'(expCt[63 - 4*j -: 4]));
      @(negedge clk);
      if (j == 0) check(done === 1'b0, {"R8 done one cycle ", tag}, 64'(done), 64'd0);
    end
    start = 1'b0;
    check(got === expCt, {"R2 R3 R4 R5 block ", tag}, got, expCt);
    quiet = 1'b1;
    for (int c = 0; c < 4; c++) begin
      if (done || dataOut != 0) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, {"R9 quiet after output ", tag}, 64'(quiet), 64'd1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(dataOut === 4'h0 && done === 1'b0, "R1 in reset", {59'd0, done, dataOut}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(dataOut === 4'h0 && done === 1'b0, "R1 after reset", {59'd0, done, dataOut}, 64'd0);
  endtask

  task automatic testModel();
    check(refEnc(64'h0, 80'h0) === 64'h5579C1387B228445, "R5 model kat0",
          refEnc(64'h0, 80'h0), 64'h5579C1387B228445);
    check(refEnc(64'h0, '1) === 64'hE72C46C0F5945049, "R4 model kat1",
          refEnc(64'h0, '1), 64'hE72C46C0F5945049);
    check(refEnc('1, 80'h0) === 64'hA112FFC72F68417B, "R3 model kat2",
          refEnc('1, 80'h0), 64'hA112FFC72F68417B);
    check(refEnc('1, '1) === 64'h3333DCD3213210D2, "R2 model kat3",
          refEnc('1, '1), 64'h3333DCD3213210D2);
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog R7 actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testModel();
    runBlock(64'h0, 80'h0, 64'h5579C1387B228445, "zero/zero", 1'b0);
    runBlock(64'h0, '1, 64'hE72C46C0F5945049, "zero/ones", 1'b0);
    runBlock('1, 80'h0, 64'hA112FFC72F68417B, "ones/zero", 1'b0);
    runBlock('1, '1, 64'h3333DCD3213210D2, "ones/ones", 1'b0);
    runBlock(64'h0123456789ABCDEF, 80'h00112233445566778899,
             refEnc(64'h0123456789ABCDEF, 80'h00112233445566778899), "mixed", 1'b0);
    // R10: start held through the whole run changes nothing
    runBlock(64'hFEDCBA9876543210, 80'hA5A5_0F0F_3C3C_C3C3_5A5A,
             refEnc(64'hFEDCBA9876543210, 80'hA5A5_0F0F_3C3C_C3C3_5A5A), "R10 busy start", 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule